// File: doc/BRIEF.md
# Interleaved MSI, INTx and Error Interrupt Aggregator

This block gathers three kinds of interrupt sources behind one register port and turns them into output lines. Message-signalled vectors (32 by default) are spread across eight groups in an interleaved fashion. The group is the low three bits of the vector and the bit inside the group is the upper bits. Four level-sensitive legacy INTx inputs and six error pulses are collected in the same way. Each source bank has a sticky status register that is cleared by writing 1, plus a mask. The mask is changed through separate set and clear registers, so software never needs a read-modify-write.

Every MSI group and every INTx source drives its own output line, and all error sources share one line. A line is the registered OR of the enabled pending bits. Software acknowledges a line by writing its index to the end-of-interrupt register: indices 0 to 3 select INTx 0 to 3, and 4 + g selects MSI group g. The acknowledged line drops for one cycle and then follows the pending state again. An MSI can arrive either on a dedicated inbound strobe or as a register write of the vector number.

Top module: `irq_aggregator`

## Requirements
- R1: MSI vector v, from `msi_wr_i`/`msi_vec_i` or from a register write of v (data bits [4:0]) to offset 0x054, sets bit v/8 of MSI group v%8. Group g's status register is at 0x104 + 0x10*g.
- R2: Writing 1 to a status bit clears only that bit. Bits written with 0 keep their value.
- R3: Per bank, writing 1 to an enable-set register bit (status offset + 4) sets only that enable bit. Writing 1 to an enable-clear register bit (status offset + 8) clears only that bit. Reading either register returns the enable mask.
- R4: An output line is high in the cycle after its bank had at least one bit that was both pending and enabled, and low otherwise.
- R5: Writing index k to the EOI register at 0x050 forces line k low in the next cycle; k = 0..3 selects INTx k and k = 4+g selects MSI group g. The line then re-asserts if the source is still pending. Indices of 12 or more have no effect.
- R6: INTx input i sets bit 0 of the status register at 0x184 + 0x10*i while the input is high. Its enable-set and enable-clear registers are at +4 and +8, and it drives `intx_irq_o[i]`.
- R7: The error status register is at 0x1C4, with enable-set at 0x1C8 and enable-clear at 0x1CC. Its bits are: 0 system, 1 fatal, 2 non-fatal, 3 correctable, 4 AXI tag lookup fatal, 5 ECRC. A pulse on `err_i` latches into status and drives `err_irq_o`.
- R8: When a source event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: After reset, all status bits, all enable bits and all output lines are 0.
- R10: A masked source is still recorded and readable in status, but its line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register write byte offset |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 12 | Register read byte offset |
| rd_data_o | output | 32 | Register read data (combinational) |
| msi_wr_i | input | 1 | Inbound MSI strobe |
| msi_vec_i | input | 5 | Inbound MSI vector number |
| intx_i | input | 4 | Legacy INTx levels |
| err_i | input | 6 | Error event pulses |
| msi_irq_o | output | 8 | One line per MSI group |
| intx_irq_o | output | 4 | One line per INTx source |
| err_irq_o | output | 1 | Combined error line |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a new source event and a write-1-to-clear on the same status bit. The bench provokes it with the MSI strobe against a group status write, an INTx input held high during its clear, and an error pulse coinciding with an error clear. It then reads status back and expects the bit still set. The second pair is an EOI write and a source that is still pending: the scoreboard samples the line right after the EOI edge and expects it low, then expects it high one cycle later.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int OFS_EOI       = 'h050;
  localparam int OFS_MSI_TGT   = 'h054;
  localparam int OFS_MSI_BASE  = 'h104;
  localparam int OFS_INTX_BASE = 'h184;
  localparam int OFS_ERR_BASE  = 'h1C4;
  localparam int OFS_STRIDE    = 'h10;
  localparam int OFS_SET       = 4;
  localparam int OFS_CLR       = 8;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_STAT,
    ACC_SET,
    ACC_CLR
  } acc_e;

  // bank order: INTx 0..n-1, MSI groups, error bank last
  function automatic int bank_base(int b, int n_intx, int n_grp);
    if (b < n_intx) return OFS_INTX_BASE + OFS_STRIDE * b;
    else if (b < n_intx + n_grp) return OFS_MSI_BASE + OFS_STRIDE * (b - n_intx);
    else return OFS_ERR_BASE;
  endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_agg_pkg::*;
#(
  parameter int AW         = 12,
  parameter int INTX_NUM   = 4,
  parameter int MSI_GROUPS = 8,
  localparam int NB        = INTX_NUM + MSI_GROUPS + 1
) (
  input  logic [AW-1:0] addr_i,
  output logic [NB-1:0] hit_o,
  output acc_e          acc_o
);

  logic [NB-1:0] h_st, h_set, h_clr;

  for (genvar b = 0; b < NB; b++) begin : g_dec
    localparam int BASE = bank_base(b, INTX_NUM, MSI_GROUPS);
    assign h_st[b]  = (addr_i == AW'(BASE));
    assign h_set[b] = (addr_i == AW'(BASE + OFS_SET));
    assign h_clr[b] = (addr_i == AW'(BASE + OFS_CLR));
  end

  always_comb begin
    hit_o = h_st | h_set | h_clr;
    if (|h_st)       acc_o = ACC_STAT;
    else if (|h_set) acc_o = ACC_SET;
    else if (|h_clr) acc_o = ACC_CLR;
    else             acc_o = ACC_NONE;
  end

endmodule

// File: rtl/irq_msi_demux.sv
module irq_msi_demux #(
  parameter int MSI_GROUPS = 8,
  parameter int MSI_BITS   = 4,
  localparam int VW        = $clog2(MSI_GROUPS * MSI_BITS),
  localparam int GW        = $clog2(MSI_GROUPS)
) (
  input  logic                                a_vld_i,
  input  logic [VW-1:0]                       a_vec_i,
  input  logic                                b_vld_i,
  input  logic [VW-1:0]                       b_vec_i,
  output logic [MSI_GROUPS-1:0][MSI_BITS-1:0] evt_o
);

  // low bits pick the group, high bits pick the bit inside it
  always_comb begin
    evt_o = '0;
    if (a_vld_i) evt_o[a_vec_i[GW-1:0]][a_vec_i[VW-1:GW]] = 1'b1;
    if (b_vld_i) evt_o[b_vec_i[GW-1:0]][b_vec_i[VW-1:GW]] = 1'b1;
  end

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         w1c_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         eoi_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic         irq_o
);

  logic [W-1:0] st_q, en_q, st_d, en_d;
  logic         irq_q;

  always_comb begin
    // event applied after the clear so it wins
    st_d = (st_q & ~(w1c_i ? wdata_i : '0)) | evt_i;
    en_d = en_q;
    if (set_i)      en_d = en_q | wdata_i;
    else if (clr_i) en_d = en_q & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      en_q  <= en_d;
      irq_q <= !eoi_i && |(st_q & en_q);
    end
  end

  assign status_o = st_q;
  assign enable_o = en_q;
  assign irq_o    = irq_q;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int AW         = 12,
  parameter int DW         = 32,
  parameter int MSI_GROUPS = 8,
  parameter int MSI_BITS   = 4,
  parameter int INTX_NUM   = 4,
  parameter int ERR_NUM    = 6,
  localparam int VW        = $clog2(MSI_GROUPS * MSI_BITS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic [DW-1:0]         wr_data_i,
  input  logic [AW-1:0]         rd_addr_i,
  output logic [DW-1:0]         rd_data_o,
  input  logic                  msi_wr_i,
  input  logic [VW-1:0]         msi_vec_i,
  input  logic [INTX_NUM-1:0]   intx_i,
  input  logic [ERR_NUM-1:0]    err_i,
  output logic [MSI_GROUPS-1:0] msi_irq_o,
  output logic [INTX_NUM-1:0]   intx_irq_o,
  output logic                  err_irq_o
);

  localparam int NB   = INTX_NUM + MSI_GROUPS + 1;
  localparam int MAXW = (MSI_BITS > ERR_NUM) ? MSI_BITS : ERR_NUM;

  logic [NB-1:0]            whit, rhit, eoi_vec, line_all;
  acc_e                     wacc, racc;
  logic [NB-1:0][MAXW-1:0]  st_all, en_all;
  logic [MSI_GROUPS-1:0][MSI_BITS-1:0] msi_evt;
  logic                     eoi_wr, tgt_wr;

  irq_reg_decode #(.AW(AW), .INTX_NUM(INTX_NUM), .MSI_GROUPS(MSI_GROUPS)) u_wdec (
    .addr_i(wr_addr_i), .hit_o(whit), .acc_o(wacc)
  );

  irq_reg_decode #(.AW(AW), .INTX_NUM(INTX_NUM), .MSI_GROUPS(MSI_GROUPS)) u_rdec (
    .addr_i(rd_addr_i), .hit_o(rhit), .acc_o(racc)
  );

  assign eoi_wr = wr_en_i && (wr_addr_i == AW'(OFS_EOI));
  assign tgt_wr = wr_en_i && (wr_addr_i == AW'(OFS_MSI_TGT));

  irq_msi_demux #(.MSI_GROUPS(MSI_GROUPS), .MSI_BITS(MSI_BITS)) u_demux (
    .a_vld_i(msi_wr_i),
    .a_vec_i(msi_vec_i),
    .b_vld_i(tgt_wr),
    .b_vec_i(wr_data_i[VW-1:0]),
    .evt_o  (msi_evt)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int W = (b < INTX_NUM) ? 1 :
                       (b < INTX_NUM + MSI_GROUPS) ? MSI_BITS : ERR_NUM;
    logic [W-1:0] evt, st, en;

    if (b < INTX_NUM) begin : g_intx
      assign evt = intx_i[b];
    end else if (b < INTX_NUM + MSI_GROUPS) begin : g_msi
      assign evt = msi_evt[b-INTX_NUM];
    end else begin : g_err
      assign evt = err_i;
    end

    // error bank has no EOI index
    assign eoi_vec[b] = (b != NB - 1) && eoi_wr && (wr_data_i == DW'(b));

    irq_src_bank #(.W(W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt),
      .w1c_i   (wr_en_i && whit[b] && (wacc == ACC_STAT)),
      .set_i   (wr_en_i && whit[b] && (wacc == ACC_SET)),
      .clr_i   (wr_en_i && whit[b] && (wacc == ACC_CLR)),
      .wdata_i (wr_data_i[W-1:0]),
      .eoi_i   (eoi_vec[b]),
      .status_o(st),
      .enable_o(en),
      .irq_o   (line_all[b])
    );

    assign st_all[b] = MAXW'(st);
    assign en_all[b] = MAXW'(en);
  end

  always_comb begin
    rd_data_o = '0;
    for (int b = 0; b < NB; b++) begin
      if (rhit[b]) begin
        case (racc)
          ACC_STAT:         rd_data_o = DW'(st_all[b]);
          ACC_SET, ACC_CLR: rd_data_o = DW'(en_all[b]);
          default:          ;
        endcase
      end
    end
  end

  assign intx_irq_o = line_all[INTX_NUM-1:0];
  assign msi_irq_o  = line_all[INTX_NUM+MSI_GROUPS-1:INTX_NUM];
  assign err_irq_o  = line_all[NB-1];

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int AW         = 12,
  parameter int DW         = 32,
  parameter int MSI_GROUPS = 8,
  parameter int MSI_BITS   = 4,
  parameter int INTX_NUM   = 4,
  parameter int ERR_NUM    = 6,
  localparam int VW        = $clog2(MSI_GROUPS * MSI_BITS),
  localparam int NB        = INTX_NUM + MSI_GROUPS + 1,
  localparam int MAXW      = (MSI_BITS > ERR_NUM) ? MSI_BITS : ERR_NUM
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   wr_en_i,
  input logic [AW-1:0]          wr_addr_i,
  input logic [DW-1:0]          wr_data_i,
  input logic                   msi_wr_i,
  input logic [VW-1:0]          msi_vec_i,
  input logic [NB-1:0][MAXW-1:0] st_all_i,
  input logic [NB-1:0][MAXW-1:0] en_all_i,
  input logic [NB-1:0]          line_all_i
);

  // R9
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (line_all_i == '0 && st_all_i == '0 && en_all_i == '0);
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_line
    // R4
    line_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_all_i[b] |-> $past(|(st_all_i[b] & en_all_i[b])));

    if (b < NB - 1) begin : g_eoi
      // R5
      eoi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == AW'(OFS_EOI) && wr_data_i == DW'(b)) |=> !line_all_i[b]);
    end
  end

  for (genvar g = 0; g < MSI_GROUPS; g++) begin : g_grp
    for (genvar k = 0; k < MSI_BITS; k++) begin : g_bit
      // R8
      msi_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (msi_wr_i && msi_vec_i == VW'(k * MSI_GROUPS + g)) |=> st_all_i[INTX_NUM+g][k]);
    end
  end

  // R3
  err_en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == AW'(OFS_ERR_BASE + OFS_SET))
    |=> ((en_all_i[NB-1][ERR_NUM-1:0] & $past(wr_data_i[ERR_NUM-1:0]))
         == $past(wr_data_i[ERR_NUM-1:0])));

  // R3
  err_en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == AW'(OFS_ERR_BASE + OFS_CLR))
    |=> ((en_all_i[NB-1][ERR_NUM-1:0] & $past(wr_data_i[ERR_NUM-1:0])) == '0));

endmodule

bind irq_aggregator irq_aggregator_chk #(
  .AW(AW), .DW(DW), .MSI_GROUPS(MSI_GROUPS), .MSI_BITS(MSI_BITS),
  .INTX_NUM(INTX_NUM), .ERR_NUM(ERR_NUM)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .msi_wr_i  (msi_wr_i),
  .msi_vec_i (msi_vec_i),
  .st_all_i  (st_all),
  .en_all_i  (en_all),
  .line_all_i(line_all)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        msi_wr = 1'b0;
  logic [4:0]  msi_vec = '0;
  logic [3:0]  intx = '0;
  logic [5:0]  err = '0;
  logic [7:0]  msi_irq;
  logic [3:0]  intx_irq;
  logic        err_irq;
  wire  [12:0] lines = {err_irq, msi_irq, intx_irq};

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .msi_wr_i(msi_wr), .msi_vec_i(msi_vec),
    .intx_i(intx), .err_i(err),
    .msi_irq_o(msi_irq), .intx_irq_o(intx_irq), .err_irq_o(err_irq)
  );

  typedef struct {
    logic [11:0] addr;
    logic [31:0] rd;
    logic [12:0] lines;
    bit          use_lines;
    string       req;
  } item_t;

  item_t sb_q[$];
  item_t it;

  // monitor: one expected item per cycle, sampled at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      n_chk++;
      if (rd_data !== it.rd) begin
        n_fail++;
        $display("FAIL %s: rd[%h] = %h, expected %h", it.req, it.addr, rd_data, it.rd);
      end
      if (it.use_lines) begin
        n_chk++;
        if (lines !== it.lines) begin
          n_fail++;
          $display("FAIL %s: lines = %b, expected %b", it.req, lines, it.lines);
        end
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic put(input logic [11:0] a, input logic [31:0] d,
                     input logic [12:0] l, input string req);
    rd_addr = a;
    sb_q.push_back('{addr: a, rd: d, lines: l, use_lines: 1'b1, req: req});
  endtask

  task automatic chk(input logic [11:0] a, input logic [31:0] d,
                     input logic [12:0] l, input string req);
    put(a, d, l, req);
    cyc();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic msi(input logic [4:0] v);
    msi_wr = 1'b1; msi_vec = v;
    cyc();
    msi_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    #2 rst_ni = 1'b0;
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();

    // R9 reset state
    chk(12'h104, 32'h0, 13'h0, "R9 msi status");
    chk(12'h108, 32'h0, 13'h0, "R9 msi enable");
    chk(12'h1C4, 32'h0, 13'h0, "R9 err status");

    // R10 vector 13 -> group 5 bit 1, masked
    msi(5'd13);
    chk(12'h154, 32'h2, 13'h0, "R10 masked msi");

    // R3 enable set, line comes up (R4)
    wr(12'h158, 32'h2);
    chk(12'h158, 32'h2, 13'h1 << 9, "R3 enable set readback");
    chk(12'h15C, 32'h2, 13'h1 << 9, "R4 line on enabled pending");

    // R1 vector via register write: 29 -> group 5 bit 3
    wr(12'h054, 32'd29);
    chk(12'h154, 32'hA, 13'h1 << 9, "R1 register msi target");

    // R2 clear only bit 3
    wr(12'h154, 32'h8);
    chk(12'h154, 32'h2, 13'h1 << 9, "R2 w1c single bit");

    // R5 EOI group 5 = index 9
    put(12'h154, 32'h2, 13'h0, "R5 eoi hold");
    wr(12'h050, 32'd9);
    chk(12'h154, 32'h2, 13'h1 << 9, "R5 eoi reassert");
    wr(12'h154, 32'h2);
    chk(12'h154, 32'h0, 13'h0, "R2 w1c drops line");

    // R4 pending bit with its enable off
    msi(5'd5);
    chk(12'h154, 32'h1, 13'h0, "R4 unmasked bit only");
    wr(12'h154, 32'h1);

    // R6 INTx 1
    wr(12'h198, 32'h1);
    intx[1] = 1'b1;
    cyc();
    chk(12'h194, 32'h1, 13'h1 << 1, "R6 intx status and line");
    put(12'h194, 32'h1, 13'h1 << 1, "R5 eoi index 15 ignored");
    wr(12'h050, 32'd15);
    intx[1] = 1'b0;
    wr(12'h194, 32'h1);
    chk(12'h194, 32'h0, 13'h0, "R6 intx cleared");

    // R8 INTx held high during its clear
    intx[2] = 1'b1;
    cyc();
    wr(12'h1A4, 32'h1);
    chk(12'h1A4, 32'h1, 13'h0, "R8 intx level wins");
    intx[2] = 1'b0;
    wr(12'h1A4, 32'h1);
    chk(12'h1A4, 32'h0, 13'h0, "R6 intx released");

    // R7 error bank: bits 2 (non-fatal) and 5 (ECRC)
    wr(12'h1C8, 32'h3F);
    err = 6'h24;
    cyc();
    err = 6'h0;
    chk(12'h1C4, 32'h24, 13'h1 << 12, "R7 error status and line");
    wr(12'h1CC, 32'h24);
    chk(12'h1C8, 32'h1B, 13'h0, "R10 error masked");
    wr(12'h1C4, 32'h4);
    chk(12'h1C4, 32'h20, 13'h0, "R2 error w1c");

    // R8 MSI strobe against clear, vector 2 -> group 2 bit 0
    msi(5'd2);
    chk(12'h124, 32'h1, 13'h0, "R1 vector 2 placement");
    msi_wr = 1'b1; msi_vec = 5'd2;
    wr(12'h124, 32'h1);
    msi_wr = 1'b0;
    chk(12'h124, 32'h1, 13'h0, "R8 msi wins over w1c");
    wr(12'h124, 32'h1);
    chk(12'h124, 32'h0, 13'h0, "R2 msi w1c alone");

    // R8 error pulse against clear of system bit
    err = 6'h1;
    wr(12'h1C4, 32'h1);
    err = 6'h0;
    chk(12'h1C4, 32'h21, 13'h1 << 12, "R8 error event wins");

    // R5 index 12 does not acknowledge the error line
    put(12'h1C4, 32'h21, 13'h1 << 12, "R5 eoi index 12 ignored");
    wr(12'h050, 32'd12);

    // R3 set then clear selected bits
    wr(12'h108, 32'hF);
    wr(12'h10C, 32'h5);
    chk(12'h108, 32'hA, 13'h1 << 12, "R3 set/clear per bit");
    chk(12'h10C, 32'hA, 13'h1 << 12, "R3 clear reg reads mask");

    cyc();
    done = 1;
    finish_run();
  end

endmodule